// File: doc/BRIEF.md
# Two-Channel Doorbell DMA Controller

The block copies blocks of bytes from one memory address to another. It has two independent directions, and each direction has two channels. Each channel has its own descriptor words: a control word, a byte length, and a 64-bit source and a 64-bit destination address, each address split into a low word and a high word. Software fills in a descriptor. It then writes the channel index to the direction's doorbell register. The direction's mover then reads the source and writes the destination, one 4-byte beat at a time.

Each direction keeps a status word with per-channel completion flags and per-channel failure flags, and a write-one-to-clear register for them. Each direction also has a global enable. When software turns the enable off, the engine finishes the transfer it is running before the enable reads back as zero. Channels that were only queued are failed at once. One interrupt line reports any flagged channel whose control word allows it.

Both directions share one memory request port and one response channel, each with a valid/ready handshake. The block holds a request steady until the memory accepts it. It takes a read response only while it is waiting for one. Writes are posted and get no response. There is at most one read outstanding.

Top module: `dbdma_ctrl`

## Requirements
- R1: After reset, every descriptor word, both enables, both status words and the interrupt read as zero, and no memory request is presented.
- R2: Register map. The read direction is at 0x000 and the write direction at 0x200. Channel c of a direction is at base + c*0x40. Within a channel: control 0x00, length 0x08, source low/high 0x0C/0x10, destination low/high 0x14/0x18. Per direction: enable 0x100 (bit 0), doorbell 0x104, status 0x108, clear 0x10C. Descriptor words read back as written.
- R3: Writing 0 or 1 to an enabled direction's doorbell copies `length` bytes of that channel from source to destination in ascending 4-byte beats, each beat a read then a write. When the copy ends, status bit c (the done flag) is set. A doorbell value other than 0 or 1 has no effect.
- R4: On the last beat, the write byte enables cover only the bytes up to the length, so no byte past the length changes. A length of zero sets the done flag with no memory traffic.
- R5: A transfer whose length exceeds MAX_LEN (320) sets status bit 16+c (the abort flag) when it would start, and makes no memory traffic.
- R6: A doorbell for a channel that is queued or running sets that channel's abort flag and leaves the running copy intact.
- R7: A doorbell while the direction's enable is off sets the channel's abort flag and makes no memory traffic.
- R8: Writing a value to the clear register clears exactly the status bits set in that value. A flag set in the same cycle is kept.
- R9: Writing 0 to the enable stops new transfers. Queued channels get their abort flag. The enable reads 1 until the running transfer has finished, and 0 after that. Writing 1 restarts the direction.
- R10: `irq` is high while any channel has a done or abort flag set and has bit 3 or bit 4 of its control word set.
- R11: A memory request is held with stable fields until it is accepted. At most one read is outstanding. The two directions can run at the same time over the shared port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address, for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_req_addr | output | 64 | Beat byte address, 4-byte aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Block accepts the read response |
| mem_rsp_data | input | 32 | Read response data |
| irq | output | 1 | Interrupt request |

## Verification
A stale channel index or a wrong byte count inside the mover shows up in memory at the end of the copy. The bench checks every byte of the destination and the sentinel bytes after it, and counts the beats on the port. A wrong busy or enable state shows up within two cycles of a doorbell, as an abort flag that should not be there or one that is missing. It also shows up when the enable is read back during a drain. Arbiter ownership errors show up as a request that moves while it is stalled, or as corrupted data when both directions run at once.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  localparam int NCH       = 2;
  localparam int CH_W      = 1;
  localparam int NDIR      = 2;
  localparam int NFLD      = 6;
  localparam int ADDR_W    = 64;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int ABORT_LSB = 16;
  localparam int IRQ_LOC_B = 3;
  localparam int IRQ_REM_B = 4;

  localparam logic [2:0] F_CTRL = 3'd0;
  localparam logic [2:0] F_LEN  = 3'd1;
  localparam logic [2:0] F_SLO  = 3'd2;
  localparam logic [2:0] F_SHI  = 3'd3;
  localparam logic [2:0] F_DLO  = 3'd4;
  localparam logic [2:0] F_DHI  = 3'd5;

  localparam logic [1:0] G_EN   = 2'd0;
  localparam logic [1:0] G_BELL = 2'd1;
  localparam logic [1:0] G_STAT = 2'd2;
  localparam logic [1:0] G_CLR  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_FINISH
  } mover_state_e;
endpackage

// File: rtl/dbdma_arb.sv
module dbdma_arb
  import dbdma_pkg::*;
#(
  parameter int N = NDIR
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               s_valid,
  input  logic [N-1:0]               s_we,
  input  logic [N-1:0][ADDR_W-1:0]   s_addr,
  input  logic [N-1:0][DATA_W-1:0]   s_wdata,
  input  logic [N-1:0][BE_W-1:0]     s_be,
  output logic [N-1:0]               s_ready,
  output logic [N-1:0]               s_rsp_valid,
  input  logic [N-1:0]               s_rsp_ready,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic                       m_we,
  output logic [ADDR_W-1:0]          m_addr,
  output logic [DATA_W-1:0]          m_wdata,
  output logic [BE_W-1:0]            m_be,
  input  logic                       m_rsp_valid,
  output logic                       m_rsp_ready
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          locked_q;
  logic [IW-1:0] owner_q, prio_q, gnt;
  logic          any_req;

  // The owner of the open beat keeps the port. Otherwise the search
  // rotates, starting from the requester after the last owner.
  always_comb begin
    gnt     = owner_q;
    any_req = |s_valid;
    if (!locked_q) begin
      gnt = prio_q;
      for (int k = N - 1; k >= 0; k--) begin
        if (s_valid[(int'(prio_q) + k) % N]) gnt = IW'((int'(prio_q) + k) % N);
      end
    end
  end

  assign m_valid     = s_valid[gnt] && (locked_q || any_req);
  assign m_we        = s_we[gnt];
  assign m_addr      = s_addr[gnt];
  assign m_wdata     = s_wdata[gnt];
  assign m_be        = s_be[gnt];
  assign m_rsp_ready = locked_q && s_rsp_ready[owner_q];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      s_ready[i]     = (gnt == IW'(i)) && m_valid && m_ready;
      s_rsp_valid[i] = locked_q && (owner_q == IW'(i)) && m_rsp_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      prio_q   <= '0;
    end else if (!locked_q) begin
      if (any_req) begin
        locked_q <= 1'b1;
        owner_q  <= gnt;
      end
    end else if (m_valid && m_ready && m_we) begin
      locked_q <= 1'b0;
      prio_q   <= IW'((int'(owner_q) + 1) % N);
    end
  end

  // R11: a stalled request stays on the port unchanged
  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we)));
endmodule

// File: rtl/dbdma_dir.sv
module dbdma_dir
  import dbdma_pkg::*;
#(
  parameter int MAX_LEN = 320
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [8:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_we,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_wdata,
  output logic [BE_W-1:0]    req_be,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               irq
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  logic [31:0]       desc_q [NCH][NFLD];
  logic [NCH-1:0]    armed_q, done_q, abort_q;
  logic              en_q;
  mover_state_e      state_q;
  logic [CH_W-1:0]   act_q;
  logic [LEN_W-1:0]  rem_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DATA_W-1:0] data_q;

  // register decode
  logic            glb_hit, desc_hit, fld_ok;
  logic [2:0]      fld;
  logic            csel;
  logic [1:0]      gsel;
  logic            desc_we, en_we, bell_we, clr_we;

  always_comb begin
    fld_ok = 1'b1;
    fld    = F_CTRL;
    case (addr[5:0])
      6'h00:   fld = F_CTRL;
      6'h08:   fld = F_LEN;
      6'h0C:   fld = F_SLO;
      6'h10:   fld = F_SHI;
      6'h14:   fld = F_DLO;
      6'h18:   fld = F_DHI;
      default: fld_ok = 1'b0;
    endcase
  end

  assign csel     = addr[6];
  assign gsel     = addr[3:2];
  assign desc_hit = !addr[8] && !addr[7] && fld_ok;
  assign glb_hit  = addr[8] && (addr[7:4] == 4'h0) && (addr[1:0] == 2'b00);
  assign desc_we  = wr_en && desc_hit;
  assign en_we    = wr_en && glb_hit && (gsel == G_EN);
  assign bell_we  = wr_en && glb_hit && (gsel == G_BELL);
  assign clr_we   = wr_en && glb_hit && (gsel == G_CLR);

  // doorbell and channel selection
  logic            bell_ok, bell_abort, bell_arm, off_wr, mover_busy;
  logic [CH_W-1:0] bell_ch, pick_ch;
  logic [NCH-1:0]  busy, pick_mask, abort_set, done_set, clr_done, clr_abort;
  logic            pick_go, pick_bad;
  logic [31:0]     pick_len;

  assign mover_busy = (state_q != ST_IDLE);
  assign busy       = armed_q | (mover_busy ? (NCH'(1) << act_q) : '0);
  assign bell_ok    = bell_we && (wdata < 32'(NCH));
  assign bell_ch    = wdata[CH_W-1:0];
  assign bell_abort = bell_ok && (!en_q || busy[bell_ch]);
  assign bell_arm   = bell_ok && !bell_abort;
  assign off_wr     = en_we && !wdata[0];

  always_comb begin
    pick_ch = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (armed_q[c]) pick_ch = CH_W'(c);
    end
  end

  assign pick_go   = (state_q == ST_IDLE) && en_q && (|armed_q);
  assign pick_len  = desc_q[pick_ch][F_LEN];
  assign pick_bad  = pick_len > 32'(MAX_LEN);
  assign pick_mask = pick_go ? (NCH'(1) << pick_ch) : '0;

  always_comb begin
    abort_set = '0;
    if (bell_abort)          abort_set = abort_set | (NCH'(1) << bell_ch);
    if (pick_go && pick_bad) abort_set = abort_set | pick_mask;
    if (off_wr)              abort_set = abort_set | (armed_q & ~pick_mask);
    done_set  = (state_q == ST_FINISH) ? (NCH'(1) << act_q) : '0;
    clr_done  = clr_we ? wdata[NCH-1:0] : '0;
    clr_abort = clr_we ? wdata[ABORT_LSB +: NCH] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int f = 0; f < NFLD; f++) desc_q[c][f] <= '0;
      armed_q <= '0;
      done_q  <= '0;
      abort_q <= '0;
      en_q    <= 1'b0;
    end else begin
      if (desc_we) desc_q[csel][fld] <= wdata;
      if (en_we)   en_q <= wdata[0];
      done_q  <= (done_q & ~clr_done) | done_set;
      abort_q <= (abort_q & ~clr_abort) | abort_set;
      if (off_wr) armed_q <= '0;
      else armed_q <= (armed_q & ~pick_mask) | (bell_arm ? (NCH'(1) << bell_ch) : '0);
    end
  end

  // beat mover
  logic last_beat;
  assign last_beat = rem_q <= LEN_W'(BE_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      rem_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (pick_go && !pick_bad) begin
          act_q   <= pick_ch;
          rem_q   <= pick_len[LEN_W-1:0];
          src_q   <= {desc_q[pick_ch][F_SHI], desc_q[pick_ch][F_SLO]};
          dst_q   <= {desc_q[pick_ch][F_DHI], desc_q[pick_ch][F_DLO]};
          state_q <= (pick_len == 32'd0) ? ST_FINISH : ST_RD_REQ;
        end
        ST_RD_REQ:  if (req_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) begin
          data_q  <= rsp_data;
          state_q <= ST_WR_REQ;
        end
        ST_WR_REQ: if (req_ready) begin
          if (last_beat) state_q <= ST_FINISH;
          else begin
            rem_q   <= rem_q - LEN_W'(BE_W);
            src_q   <= src_q + ADDR_W'(BE_W);
            dst_q   <= dst_q + ADDR_W'(BE_W);
            state_q <= ST_RD_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign req_we    = (state_q == ST_WR_REQ);
  assign req_addr  = req_we ? dst_q : src_q;
  assign req_wdata = data_q;
  assign req_be    = (!req_we || !last_beat || rem_q[1:0] == 2'b00) ? '1
                   : BE_W'((BE_W'(1) << rem_q[1:0]) - BE_W'(1));
  assign rsp_ready = (state_q == ST_RD_WAIT);

  // interrupt and register read
  logic [NCH-1:0] irq_en;
  always_comb begin
    for (int c = 0; c < NCH; c++)
      irq_en[c] = desc_q[c][F_CTRL][IRQ_LOC_B] | desc_q[c][F_CTRL][IRQ_REM_B];
  end
  assign irq = |((done_q | abort_q) & irq_en);

  always_comb begin
    rdata = '0;
    if (desc_hit) rdata = desc_q[csel][fld];
    else if (glb_hit) begin
      case (gsel)
        G_EN:    rdata = {31'b0, en_q | mover_busy};
        G_STAT:  rdata = (32'(abort_q) << ABORT_LSB) | 32'(done_q);
        default: rdata = '0;
      endcase
    end
  end

  // R4: a trimmed byte-enable write ends the copy
  assert_partial_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_ready && req_be != '1) |=> (state_q == ST_FINISH));
  // R9: an engine that is off and idle starts nothing
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && state_q == ST_IDLE) |=> (state_q == ST_IDLE));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R3: completion raises the channel's done flag
    assert_finish_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FINISH && act_q == CH_W'(c)) |=> done_q[c]);
    // R6: doorbell on a busy channel fails it
    assert_busy_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bell_ok && en_q && busy[c] && bell_ch == CH_W'(c)) |=> abort_q[c]);
    // R7: doorbell while off fails the channel
    assert_off_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bell_ok && !en_q && bell_ch == CH_W'(c)) |=> abort_q[c]);
  end
endmodule

// File: rtl/dbdma_ctrl.sv
module dbdma_ctrl
  import dbdma_pkg::*;
#(
  parameter int MAX_LEN = 320
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [9:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  output logic [BE_W-1:0]    mem_req_be,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic               irq
);
  logic [NDIR-1:0][31:0]       dir_rdata;
  logic [NDIR-1:0]             dir_irq, q_valid, q_we, q_ready, r_valid, r_ready;
  logic [NDIR-1:0][ADDR_W-1:0] q_addr;
  logic [NDIR-1:0][DATA_W-1:0] q_wdata;
  logic [NDIR-1:0][BE_W-1:0]   q_be;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    dbdma_dir #(.MAX_LEN(MAX_LEN)) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr && (reg_addr[9] == d[0])),
      .addr      (reg_addr[8:0]),
      .wdata     (reg_wdata),
      .rdata     (dir_rdata[d]),
      .req_valid (q_valid[d]),
      .req_ready (q_ready[d]),
      .req_we    (q_we[d]),
      .req_addr  (q_addr[d]),
      .req_wdata (q_wdata[d]),
      .req_be    (q_be[d]),
      .rsp_valid (r_valid[d]),
      .rsp_ready (r_ready[d]),
      .rsp_data  (mem_rsp_data),
      .irq       (dir_irq[d])
    );
  end

  dbdma_arb #(.N(NDIR)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (q_valid),
    .s_we        (q_we),
    .s_addr      (q_addr),
    .s_wdata     (q_wdata),
    .s_be        (q_be),
    .s_ready     (q_ready),
    .s_rsp_valid (r_valid),
    .s_rsp_ready (r_ready),
    .m_valid     (mem_req_valid),
    .m_ready     (mem_req_ready),
    .m_we        (mem_req_write),
    .m_addr      (mem_req_addr),
    .m_wdata     (mem_req_wdata),
    .m_be        (mem_req_be),
    .m_rsp_valid (mem_rsp_valid),
    .m_rsp_ready (mem_rsp_ready)
  );

  assign reg_rdata = dir_rdata[reg_addr[9]];
  assign irq       = |dir_irq;
endmodule

// File: tb/dbdma_ctrl_tb.sv
module dbdma_ctrl_tb;
  localparam int CLK_NS = 5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready, irq;
  logic        mem_req_ready, mem_rsp_valid;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_data;
  logic [3:0]  mem_req_be;

  always #(CLK_NS / 2.0) clk = ~clk;

  dbdma_ctrl u_dut (.*);

  // memory model: one-cycle read latency, periodic back-pressure
  logic [31:0] mem [256];
  logic [31:0] rsp_d;
  logic        rsp_v, rdy, stall;
  logic [63:0] stall_addr;
  int          cyc, rd_cnt, wr_cnt, hold_bad;
  assign mem_req_ready = rdy;
  assign mem_rsp_valid = rsp_v;
  assign mem_rsp_data  = rsp_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_v <= 1'b0; rdy <= 1'b0; stall <= 1'b0; cyc <= 0;
      rd_cnt <= 0; wr_cnt <= 0; hold_bad <= 0; stall_addr <= '0; rsp_d <= '0;
    end else begin
      cyc <= cyc + 1;
      rdy <= (cyc % 3) != 1;
      if (mem_rsp_valid && mem_rsp_ready) rsp_v <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          for (int b = 0; b < 4; b++)
            if (mem_req_be[b]) mem[mem_req_addr[9:2]][8*b +: 8] <= mem_req_wdata[8*b +: 8];
          wr_cnt <= wr_cnt + 1;
        end else begin
          rsp_v  <= 1'b1;
          rsp_d  <= mem[mem_req_addr[9:2]];
          rd_cnt <= rd_cnt + 1;
        end
      end
      if (stall && (!mem_req_valid || mem_req_addr != stall_addr)) hold_bad <= hold_bad + 1;
      stall      <= mem_req_valid && !mem_req_ready;
      stall_addr <= mem_req_addr;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = 10'(a);
    #1 d = reg_rdata;
  endtask

  function automatic int gbase(int dir); return dir * 'h200 + 'h100; endfunction

  task automatic prog(int dir, int ch, int sw, int dw, int len, int ctrl);
    int b = dir * 'h200 + ch * 'h40;
    wr(b + 'h00, ctrl);  wr(b + 'h08, len);
    wr(b + 'h0C, sw * 4); wr(b + 'h10, 0);
    wr(b + 'h14, dw * 4); wr(b + 'h18, 0);
  endtask

  task automatic ring(int dir, int ch); wr(gbase(dir) + 4, ch); endtask
  task automatic clr(int dir, logic [31:0] m); wr(gbase(dir) + 'hC, m); endtask

  task automatic wait_stat(int dir, logic [31:0] mask, output logic [31:0] st);
    for (int i = 0; i < 4000; i++) begin
      rd(gbase(dir) + 8, st);
      if ((st & mask) == mask) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic fill_dst(int dw, int len);
    for (int w = dw; w <= dw + len / 4 + 1; w++) mem[w] = 32'hA5A5A5A5;
  endtask

  function automatic logic [7:0] mbyte(int a);
    return mem[a / 4][8 * (a % 4) +: 8];
  endfunction

  task automatic check_copy(string tag, int sw, int dw, int len);
    int bad = 0;
    for (int k = 0; k < len + 4; k++) begin
      logic [7:0] e = (k < len) ? mbyte(sw * 4 + k) : 8'hA5;
      if (mbyte(dw * 4 + k) !== e) bad++;
    end
    check(tag, bad, 0);
  endtask

  // {direction, channel, source word, destination word, length}
  localparam int VEC [6][5] = '{
    '{0, 0,  0, 128,   4},
    '{0, 1,  3, 140,   7},
    '{1, 0, 10, 160, 320},
    '{1, 1, 20, 130,   1},
    '{0, 0,  7, 200,  13},
    '{1, 1, 50, 170,   2}
  };

  initial begin
    #(CLK_NS * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] st, v;
    int w0, r0;
    for (int i = 0; i < 256; i++) mem[i] = {i[7:0] ^ 8'h5A, i[7:0] + 8'd1, ~i[7:0], i[7:0]};
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1: reset values
    rd('h100, v); check("R1 read-direction enable", v, 0);
    rd('h308, v); check("R1 write-direction status", v, 0);
    rd('h248, v); check("R1 descriptor word", v, 0);
    check("R1 irq", irq, 0);
    check("R1 request idle", mem_req_valid, 0);

    // R2: descriptor readback
    wr('h258, 32'h12345678); rd('h258, v); check("R2 dst high readback", v, 32'h12345678);
    wr('h00C, 32'h0000ABC4); rd('h00C, v); check("R2 src low readback", v, 32'h0000ABC4);
    rd('h04C, v); check("R2 other channel untouched", v, 0);

    wr('h100, 1); wr('h300, 1);
    rd('h300, v); check("R9 enable reads one", v, 1);

    // R3: table walk
    for (int i = 0; i < 6; i++) begin
      int d = VEC[i][0], c = VEC[i][1], len = VEC[i][4];
      fill_dst(VEC[i][3], len);
      prog(d, c, VEC[i][2], VEC[i][3], len, 0);
      w0 = wr_cnt;
      ring(d, c);
      wait_stat(d, 32'(1) << c, st);
      idle(1);
      check($sformatf("R3 vec%0d done flag", i), st, 32'(1) << c);
      check_copy($sformatf("R3 R4 vec%0d copy", i), VEC[i][2], VEC[i][3], len);
      check($sformatf("R4 vec%0d beat count", i), wr_cnt - w0, (len + 3) / 4);
      clr(d, st);
      rd(gbase(d) + 8, v); check($sformatf("R8 vec%0d cleared", i), v, 0);
    end

    // R3: doorbell value outside the channel range
    w0 = wr_cnt; r0 = rd_cnt;
    ring(0, 2); idle(20);
    rd('h108, v); check("R3 doorbell 2 status", v, 0);
    check("R3 doorbell 2 traffic", rd_cnt - r0, 0);

    // R4: zero length
    prog(1, 0, 0, 128, 0, 0); r0 = rd_cnt;
    ring(1, 0); wait_stat(1, 1, st);
    check("R4 zero length done", st, 1);
    check("R4 zero length traffic", rd_cnt - r0, 0);
    clr(1, st);

    // R5: over-length
    prog(0, 0, 0, 128, 324, 0); r0 = rd_cnt;
    ring(0, 0); idle(5);
    rd('h108, v); check("R5 over-length abort", v, 32'h10000);
    check("R5 over-length traffic", rd_cnt - r0, 0);
    clr(0, v);

    // R6: doorbell to a busy channel
    fill_dst(150, 320);
    prog(0, 0, 30, 150, 320, 0);
    ring(0, 0); ring(0, 0);
    wait_stat(0, 1, st);
    check("R6 busy abort plus done", st, 32'h10001);
    check_copy("R6 running copy intact", 30, 150, 320);
    clr(0, st);

    // R7: doorbell while disabled
    wr('h300, 0);
    rd('h300, v); check("R9 idle disable reads zero", v, 0);
    prog(1, 0, 0, 128, 8, 0); r0 = rd_cnt;
    ring(1, 0); idle(5);
    rd('h308, v); check("R7 disabled abort", v, 32'h10000);
    check("R7 disabled traffic", rd_cnt - r0, 0);
    clr(1, v); wr('h300, 1);

    // R8: clear only the selected bits
    prog(0, 0, 0, 128, 4, 0); prog(0, 1, 0, 140, 400, 0);
    ring(0, 0); wait_stat(0, 1, st);
    ring(0, 1); idle(4);
    rd('h108, v); check("R8 done0 and abort1", v, 32'h20001);
    clr(0, 32'h20000);
    rd('h108, v); check("R8 partial clear", v, 32'h1);
    clr(0, 32'h1);
    rd('h108, v); check("R8 full clear", v, 0);

    // R9: drain on disable
    fill_dst(150, 320);
    prog(0, 0, 40, 150, 320, 0); prog(0, 1, 0, 240, 8, 0);
    ring(0, 0); ring(0, 1); wr('h100, 0);
    rd('h100, v); check("R9 enable held during drain", v, 1);
    for (int i = 0; i < 4000 && v != 0; i++) begin @(negedge clk); rd('h100, v); end
    check("R9 enable reads zero after drain", v, 0);
    rd('h108, v); check("R9 running done, queued aborted", v, 32'h20001);
    check_copy("R9 drained copy", 40, 150, 320);
    clr(0, v); wr('h100, 1);
    rd('h100, v); check("R9 restart", v, 1);

    // R10: interrupt gating
    prog(1, 0, 0, 128, 4, 32'h8);
    ring(1, 0); wait_stat(1, 1, st); idle(1);
    check("R10 irq on done with bit3", irq, 1);
    clr(1, st); idle(1);
    check("R10 irq cleared", irq, 0);
    prog(1, 0, 0, 128, 400, 0);
    ring(1, 0); idle(4);
    check("R10 irq gated off", irq, 0);
    wr('h200, 32'h10); idle(1);
    check("R10 irq on abort with bit4", irq, 1);
    clr(1, 32'h10000); idle(1);
    check("R10 irq cleared again", irq, 0);

    // R11: both directions at once
    fill_dst(180, 64); fill_dst(220, 64);
    prog(0, 1, 60, 180, 64, 0); prog(1, 0, 90, 220, 64, 0);
    w0 = wr_cnt; r0 = rd_cnt;
    ring(0, 1); ring(1, 0);
    wait_stat(0, 2, st); check("R11 direction 0 done", st, 2);
    wait_stat(1, 1, st); check("R11 direction 1 done", st, 1);
    check_copy("R11 direction 0 copy", 60, 180, 64);
    check_copy("R11 direction 1 copy", 90, 220, 64);
    check("R11 one read per write", rd_cnt - r0, wr_cnt - w0);
    check("R11 stalled request held", hold_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule